// File: doc/BRIEF.md
# Prescaled Timer Counter Core

This block is the timebase of a general-purpose timer. It picks one of three count sources: every system clock cycle, a fixed-rate enable input, or an external clock pin. The chosen source is divided by a power-of-two prescaler. The prescaled ticks drive a 16-bit counter. That counter runs upward from a programmable start value to a programmable modulo and then returns to the start value.

Everything runs on one system clock. The fixed-rate input is sampled as a plain enable. The external pin first passes through a two-flop synchronizer and then a rising-edge detector, so each rising edge produces one source tick. For that reason the pin should toggle no faster than a quarter of the system clock rate. Each return to the start value raises a one-cycle wrap pulse. A synchronous clear input restarts the timebase from the start value.

Top module: `tmr_timebase`

## Requirements
- R1: While and after the asynchronous reset `rst_ni` is low, `count_o` is 0 and `wrap_o` is 0.
- R2: A clock edge with `sync_clr_i` high loads `init_i` into `count_o`, clears the prescaler and leaves `wrap_o` low.
- R3: With source select 1 (system clock) and prescale code 0, `count_o` rises by one on every clock edge while it is below `mod_i`.
- R4: A counter tick that finds `count_o` at or above `mod_i` loads `init_i`. `wrap_o` is then high for exactly that one cycle, together with the reloaded value.
- R5: With prescale code `ps_i` = p (0 to 7), the counter advances once every 2^p source ticks. The first advance after a restart comes on the 2^p-th tick.
- R6: With source select 2 (fixed-rate enable), the counter receives one source tick for each clock edge at which `fix_en_i` is high, and none otherwise.
- R7: With source select 3 (external pin), a rising edge of `ext_clk_i` set up before clock edge k makes the counter advance at edge k+2. A steady level or a falling edge has no effect.
- R8: On the clock edge at which `ps_i` or `src_sel_i` differs from its value at the previous edge, no counter tick happens and the prescaler restarts from zero.
- R9: With source select 0 (off), `count_o` holds its value.
- R10: When `mod_i` is below `init_i`, every counter tick reloads `init_i` and pulses `wrap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_clr_i | input | 1 | Synchronous restart: load start value, clear prescaler |
| src_sel_i | input | 2 | Source select: 0 off, 1 system clock, 2 fixed enable, 3 external pin |
| ps_i | input | 3 | Prescale code p, ratio 2^p |
| fix_en_i | input | 1 | Fixed-rate enable, at most every other cycle |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| init_i | input | 16 | Counter start value |
| mod_i | input | 16 | Counter modulo |
| count_o | output | 16 | Counter value |
| wrap_o | output | 1 | One-cycle pulse on reload to start value |

## Verification
Two events can land on the same edge: a counter reload at the modulo, and a configuration change that cancels ticks. In the same way, a wrap can meet a synchronous clear. The bench brings the counter next to its modulo and then changes the prescale code or the source on the edge where the wrap was due. It expects the count to hold and no wrap pulse, with the wrap following one prescaled period later. A mid-count clear is judged the same way: the start value must appear and `wrap_o` must stay low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_FIX = 2'd2,
    SRC_EXT = 2'd3
  } src_sel_e;
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_sel_e sel_i,
  input  logic     fix_en_i,
  input  logic     ext_clk_i,
  output logic     src_tick_o
);
  localparam int SHR_W = SYNC_STAGES + 1;

  // stages [0..SYNC_STAGES-1] synchronize, last stage holds previous level
  logic [SHR_W-1:0] ext_shr_q;
  logic             ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_shr_q <= '0;
    else         ext_shr_q <= {ext_shr_q[SHR_W-2:0], ext_clk_i};
  end

  assign ext_rise = ext_shr_q[SYNC_STAGES-1] & ~ext_shr_q[SYNC_STAGES];

  always_comb begin
    unique case (sel_i)
      SRC_SYS: src_tick_o = 1'b1;
      SRC_FIX: src_tick_o = fix_en_i;
      SRC_EXT: src_tick_o = ext_rise;
      default: src_tick_o = 1'b0;
    endcase
  end

  AST_EXT_SINGLE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise); // R7
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W  = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             src_tick_i,
  output logic             cnt_tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pcnt_q;
  logic [PS_W-1:0]  ps_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] limit;
  logic             cfg_chg;
  logic             last;

  assign cfg_chg    = (ps_i != ps_q) | (sel_i != sel_q);
  assign limit      = DIV_W'((DIV_W'(1) << ps_i) - DIV_W'(1));
  assign last       = (pcnt_q == limit);
  assign cnt_tick_o = src_tick_i & last & ~cfg_chg & ~sync_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      ps_q   <= '0;
      sel_q  <= '0;
    end else begin
      ps_q  <= ps_i;
      sel_q <= sel_i;
      if (sync_clr_i || cfg_chg) pcnt_q <= '0;
      else if (src_tick_i)       pcnt_q <= last ? '0 : pcnt_q + DIV_W'(1);
    end
  end

  AST_PRESCALE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((DIV_W+1)'(pcnt_q) < ((DIV_W+1)'(1) << ps_q))); // R5
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic             cnt_tick_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q;
  logic             wrap_q;
  logic             reload;

  // also covers mod below start: count sits at start, above mod
  assign reload = (count_q >= mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else if (sync_clr_i) begin
      count_q <= init_i;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= cnt_tick_i & reload;
      if (cnt_tick_i) count_q <= reload ? init_i : count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  AST_WRAP_LOADS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (count_o == $past(init_i))); // R4
  AST_CLR_LOADS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (count_o == $past(init_i)) && !wrap_o); // R2
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_tick_i && !sync_clr_i && (count_o < mod_i)) |=>
      (count_o == $past(count_o) + CNT_W'(1)) && !wrap_o); // R3
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic [1:0]       src_sel_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             fix_en_i,
  input  logic             ext_clk_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  src_sel_e sel;
  logic     src_tick;
  logic     cnt_tick;

  assign sel = src_sel_e'(src_sel_i);

  tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) i_src_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .fix_en_i  (fix_en_i),
    .ext_clk_i (ext_clk_i),
    .src_tick_o(src_tick)
  );

  tmr_prescaler #(.PS_W(PS_W), .SEL_W(2)) i_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_clr_i(sync_clr_i),
    .ps_i      (ps_i),
    .sel_i     (src_sel_i),
    .src_tick_i(src_tick),
    .cnt_tick_o(cnt_tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_clr_i(sync_clr_i),
    .cnt_tick_i(cnt_tick),
    .init_i    (init_i),
    .mod_i     (mod_i),
    .count_o   (count_o),
    .wrap_o    (wrap_o)
  );

  AST_CFG_SWALLOWS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_sel_i != $past(src_sel_i)) || (ps_i != $past(ps_i))) && !sync_clr_i
      |=> $stable(count_o) && !wrap_o); // R8
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'd0) && !sync_clr_i |=> $stable(count_o) && !wrap_o); // R9
endmodule

// File: tb/test_tmr_timebase.sv
module test_tmr_timebase;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_clr_i = 1'b0;
  logic [1:0]  src_sel_i = 2'd0;
  logic [2:0]  ps_i = 3'd0;
  logic        fix_en_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic [15:0] init_i = 16'd0;
  logic [15:0] mod_i = 16'd0;
  logic [15:0] count_o;
  logic        wrap_o;

  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  tmr_timebase i_tmr_timebase (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_clr_i(sync_clr_i), .src_sel_i(src_sel_i),
    .ps_i(ps_i), .fix_en_i(fix_en_i), .ext_clk_i(ext_clk_i), .init_i(init_i),
    .mod_i(mod_i), .count_o(count_o), .wrap_o(wrap_o)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // restart with a given source, prescale code, start and modulo
  task automatic setup(input logic [1:0] sel, input logic [2:0] ps,
                       input logic [15:0] ini, input logic [15:0] md);
    src_sel_i = 2'd0; ps_i = ps; init_i = ini; mod_i = md; sync_clr_i = 1'b1;
    step(1);
    sync_clr_i = 1'b0; src_sel_i = sel;
    step(1); // select change edge swallows the tick
  endtask

  task automatic t_reset;
    check("R1 count in reset", count_o, 0);
    check("R1 wrap in reset", wrap_o, 0);
    rst_ni = 1'b1;
    step(1);
    check("R1 count after reset", count_o, 0);
  endtask

  task automatic t_sys_wrap;
    setup(2'd1, 3'd0, 16'd0, 16'd3);
    check("R2 start loaded", count_o, 0);
    step(1); check("R3 step1", count_o, 1);
    step(1); check("R3 step2", count_o, 2);
    step(1); check("R3 step3", count_o, 3);
    check("R4 no wrap before mod", wrap_o, 0);
    step(1); check("R4 reload", count_o, 0);
    check("R4 wrap pulse", wrap_o, 1);
    step(1); check("R4 wrap one cycle", wrap_o, 0);
    check("R4 count after wrap", count_o, 1);
  endtask

  task automatic t_prescale;
    setup(2'd1, 3'd2, 16'd5, 16'd8);
    step(3); check("R5 ps2 before 4th tick", count_o, 5);
    step(1); check("R5 ps2 4th tick", count_o, 6);
    step(4); check("R5 ps2 next", count_o, 7);
    step(4); check("R5 ps2 at mod", count_o, 8);
    step(4); check("R5 R4 ps2 reload", count_o, 5);
    check("R4 ps2 wrap", wrap_o, 1);
    setup(2'd1, 3'd7, 16'd0, 16'hFFFF);
    step(127); check("R5 ps7 before 128", count_o, 0);
    step(1); check("R5 ps7 at 128", count_o, 1);
  endtask

  task automatic t_fixed;
    setup(2'd2, 3'd0, 16'd10, 16'd100);
    step(3); check("R6 idle enable", count_o, 10);
    fix_en_i = 1'b1; step(1); fix_en_i = 1'b0; step(1);
    fix_en_i = 1'b1; step(1); fix_en_i = 1'b0; step(1);
    fix_en_i = 1'b1; step(1); fix_en_i = 1'b0;
    step(3); check("R6 three enables", count_o, 13);
  endtask

  task automatic t_ext;
    setup(2'd3, 3'd0, 16'd0, 16'd100);
    ext_clk_i = 1'b1;
    step(1); check("R7 edge k", count_o, 0);
    step(1); check("R7 edge k+1", count_o, 0);
    step(1); check("R7 edge k+2", count_o, 1);
    step(4); check("R7 high level", count_o, 1);
    ext_clk_i = 1'b0;
    step(4); check("R7 falling edge", count_o, 1);
    for (int i = 0; i < 2; i++) begin
      ext_clk_i = 1'b1; step(2);
      ext_clk_i = 1'b0; step(2);
    end
    step(2); check("R7 two more edges", count_o, 3);
  endtask

  task automatic t_cfg_change;
    setup(2'd1, 3'd1, 16'd0, 16'd100);
    step(2); check("R8 ps1 first", count_o, 1);
    step(1);
    ps_i = 3'd0; step(1); check("R8 ps change swallows", count_o, 1);
    step(1); check("R8 restart ps0", count_o, 2);
    fix_en_i = 1'b1; src_sel_i = 2'd2;
    step(1); check("R8 sel change swallows", count_o, 2);
    step(1); check("R8 R6 after sel change", count_o, 3);
    fix_en_i = 1'b0;
    // change on the edge where a wrap was due
    setup(2'd1, 3'd1, 16'd0, 16'd1);
    step(2); check("R8 at mod", count_o, 1);
    step(1); ps_i = 3'd2;
    step(1); check("R8 wrap held off count", count_o, 1);
    check("R8 wrap held off pulse", wrap_o, 0);
    step(3); check("R8 R4 before new period", wrap_o, 0);
    step(1); check("R8 R4 late wrap", wrap_o, 1);
    check("R8 R4 late reload", count_o, 0);
  endtask

  task automatic t_off_and_clr;
    setup(2'd1, 3'd0, 16'd40, 16'd100);
    step(5); check("R3 run", count_o, 45);
    src_sel_i = 2'd0;
    step(6); check("R9 off holds", count_o, 45);
    src_sel_i = 2'd1; step(3);
    init_i = 16'd7; sync_clr_i = 1'b1;
    step(1); check("R2 mid clear", count_o, 7);
    check("R2 no wrap", wrap_o, 0);
    sync_clr_i = 1'b0;
    step(1); check("R2 resumes", count_o, 8);
  endtask

  task automatic t_mod_below;
    setup(2'd1, 3'd0, 16'd20, 16'd10);
    check("R10 start", count_o, 20);
    step(1); check("R10 reload", count_o, 20);
    check("R10 wrap1", wrap_o, 1);
    step(1); check("R10 wrap2", wrap_o, 1);
    src_sel_i = 2'd0;
    step(2); check("R10 R9 off no wrap", wrap_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #23;
    t_reset();
    t_sys_wrap();
    t_prescale();
    t_fixed();
    t_ext();
    t_cfg_change();
    t_off_and_clr();
    t_mod_below();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule